// File: doc/BRIEF.md
# Relative Branch and Subroutine Sequencer

This block carries out the control-flow half of a small 16-bit accumulator machine's instruction set: the single-nibble opcodes that do not name a register. An outside fetch unit hands it the opcode nibble, the displacement byte that follows it, the program counter (already advanced past that displacement), the value of the register that produced the most recent result, the carry, and the current subroutine stack pointer register. The block decides whether a conditional branch is taken and returns the new program counter. For subroutine calls and returns it moves the return address through a byte-wide memory, using the stack pointer register as the address.

The controller is a state machine with seven states. `S_IDLE` waits for `start`. Branch, exit, break and unassigned opcodes go directly to `S_FINISH`. A subroutine call goes through `S_PUSH_LO` and `S_PUSH_HI`, which write the two return bytes, and then to `S_FINISH`. A subroutine return goes through `S_POP_HI` and `S_POP_LO`, which issue the two reads, and `S_POP_CAP`, which captures the last read byte, and then to `S_FINISH`. `S_FINISH` presents every result for one cycle with `done` and always returns to `S_IDLE`. Two events are passed on to the surrounding machine: leaving to host mode and break. The block does not act on either event itself.

Top module: `br16_unit`

## Requirements
- R1: The opcode selects the branch condition. 1: always. 2: carry clear. 3: carry set. 4: result bit 15 clear. 5: result bit 15 set. 6: result equal to 0. 7: result not 0. 8: result equal to 0xFFFF. 9: result not 0xFFFF. The condition is judged on `res_val` and `carry_in` as they stand in the cycle `start` is accepted.
- R2: When a branch is taken, `done` rises one cycle after acceptance with `pc_we`=1 and `pc_out` = `pc_in` + sign-extended `disp`, wrapping in 16 bits. This covers offsets from -128 to +127.
- R3: Opcodes 1 to 9 never raise `carry_clr`, `res_to_acc` or `r12_we`, and never touch memory.
- R4: Opcode 0xC (call) writes the low byte of `pc_in` at address `r12_in` and then the high byte at `r12_in`+1, in two consecutive cycles. `done` follows three cycles after acceptance, with `pc_we`=1, `pc_out` = the relative target, `r12_we`=1, `r12_out` = `r12_in`+2, and `carry_clr`=1 and `res_to_acc`=1.
- R5: Opcode 0xB (return) reads address `r12_in`-1 and then `r12_in`-2. Read data arrives one cycle after `mem_re`. `done` follows four cycles after acceptance with `pc_out` = {first byte, second byte}, `pc_we`=1, `r12_we`=1, `r12_out` = `r12_in`-2, and no flag outputs.
- R6: Opcode 0x0 raises `exit_evt` and opcode 0xA raises `brk_evt`, each only in the `done` cycle one cycle after acceptance. Neither writes the PC or touches memory.
- R7: Opcodes 0xD to 0xF complete one cycle after acceptance with `pc_we`=0, `pc_out` = `pc_in`, no events and no memory access, because the displacement byte has already been consumed.
- R8: When a branch is not taken, `done` comes one cycle after acceptance with `pc_we`=0 and `pc_out` = `pc_in`.
- R9: `ready` is high only in `S_IDLE`. `start` has no effect while `ready` is low, and each accepted opcode produces exactly one `done` pulse.
- R10: After reset, `ready`=1 and `done`, `pc_we`, `r12_we`, `mem_we` and `mem_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute the presented opcode |
| op_code | input | 4 | Non-register opcode nibble |
| disp | input | 8 | Signed displacement byte |
| pc_in | input | 16 | PC pointing past the displacement byte |
| res_val | input | 16 | Value of the prior-result register |
| carry_in | input | 1 | Current carry flag |
| r12_in | input | 16 | Current return stack pointer |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| ready | output | 1 | Controller idle, able to accept start |
| done | output | 1 | One-cycle completion strobe |
| pc_we | output | 1 | Load pc_out into the PC |
| pc_out | output | 16 | Next PC |
| r12_we | output | 1 | Load r12_out into the stack pointer |
| r12_out | output | 16 | Updated stack pointer |
| carry_clr | output | 1 | Clear the carry |
| res_to_acc | output | 1 | Point the prior-result index at the accumulator |
| exit_evt | output | 1 | Return-to-host event |
| brk_evt | output | 1 | Break event |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte write data |

## Verification
The overlap that matters is a new `start` arriving while a call or return is still moving bytes through memory. The bench provokes it by holding `start` high with a branch opcode through every busy cycle of a call and of a return. It then judges the result by counting `done` pulses and by confirming that `pc_out` and `r12_out` belong to the stack operation and not to the branch. The condition and target logic is swept across every non-stack opcode, extreme result values, both carry values and displacements at both ends of the range. A nested call/call/return/return sequence against a bench byte memory checks both byte order and pointer movement.

// File: rtl/br16_pkg.sv
package br16_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_LO,
        S_PUSH_HI,
        S_POP_HI,
        S_POP_LO,
        S_POP_CAP,
        S_FINISH
    } ctl_state_e;

    localparam logic [3:0] OPC_EXIT    = 4'h0;
    localparam logic [3:0] OPC_ALWAYS  = 4'h1;
    localparam logic [3:0] OPC_NO_CY   = 4'h2;
    localparam logic [3:0] OPC_CY      = 4'h3;
    localparam logic [3:0] OPC_PLUS    = 4'h4;
    localparam logic [3:0] OPC_MINUS   = 4'h5;
    localparam logic [3:0] OPC_ZERO    = 4'h6;
    localparam logic [3:0] OPC_NONZERO = 4'h7;
    localparam logic [3:0] OPC_ALLONE  = 4'h8;
    localparam logic [3:0] OPC_NOTONE  = 4'h9;
    localparam logic [3:0] OPC_BREAK   = 4'hA;
    localparam logic [3:0] OPC_SUBRET  = 4'hB;
    localparam logic [3:0] OPC_SUBCALL = 4'hC;

endpackage

// File: rtl/br16_cond.sv
module br16_cond
    import br16_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic [3:0]       op,
    input  logic [VAL_W-1:0] res,
    input  logic             cy,
    output logic             take
);
    logic is_zero;
    logic is_ones;
    logic is_neg;

    assign is_zero = (res == '0);
    assign is_ones = (res == '1);
    assign is_neg  = res[VAL_W-1];

    always_comb begin
        unique case (op)
            OPC_ALWAYS:  take = 1'b1;
            OPC_NO_CY:   take = ~cy;
            OPC_CY:      take = cy;
            OPC_PLUS:    take = ~is_neg;
            OPC_MINUS:   take = is_neg;
            OPC_ZERO:    take = is_zero;
            OPC_NONZERO: take = ~is_zero;
            OPC_ALLONE:  take = is_ones;
            OPC_NOTONE:  take = ~is_ones;
            default:     take = 1'b0;
        endcase
    end
endmodule

// File: rtl/br16_target.sv
module br16_target #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] offs,
    output logic [ADDR_W-1:0] tgt
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offs_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offs_ext = {{EXT_W{offs[DISP_W-1]}}, offs};
        end else begin : g_noext
            assign offs_ext = offs[ADDR_W-1:0];
        end
    endgenerate

    assign tgt = base + offs_ext;
endmodule

// File: rtl/br16_unit.sv
module br16_unit
    import br16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [3:0]            op_code,
    input  logic [DISP_W-1:0]     disp,
    input  logic [2*BYTE_W-1:0]   pc_in,
    input  logic [2*BYTE_W-1:0]   res_val,
    input  logic                  carry_in,
    input  logic [2*BYTE_W-1:0]   r12_in,
    input  logic [BYTE_W-1:0]     mem_rdata,
    output logic                  ready,
    output logic                  done,
    output logic                  pc_we,
    output logic [2*BYTE_W-1:0]   pc_out,
    output logic                  r12_we,
    output logic [2*BYTE_W-1:0]   r12_out,
    output logic                  carry_clr,
    output logic                  res_to_acc,
    output logic                  exit_evt,
    output logic                  brk_evt,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [2*BYTE_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]     mem_wdata
);
    localparam int ADDR_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

    ctl_state_e        state_q, state_d;
    logic [3:0]        op_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] sp_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              take_q;

    logic              take_w;
    logic [ADDR_W-1:0] tgt_w;
    logic              accept;

    br16_cond #(.VAL_W(ADDR_W)) cond_i (
        .op   (op_code),
        .res  (res_val),
        .cy   (carry_in),
        .take (take_w)
    );

    br16_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) tgt_i (
        .base (pc_in),
        .offs (disp),
        .tgt  (tgt_w)
    );

    assign accept = start && (state_q == S_IDLE);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (op_code == OPC_SUBCALL)     state_d = S_PUSH_LO;
                    else if (op_code == OPC_SUBRET) state_d = S_POP_HI;
                    else                            state_d = S_FINISH;
                end
            end
            S_PUSH_LO: state_d = S_PUSH_HI;
            S_PUSH_HI: state_d = S_FINISH;
            S_POP_HI:  state_d = S_POP_LO;
            S_POP_LO:  state_d = S_POP_CAP;
            S_POP_CAP: state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            pc_q    <= '0;
            tgt_q   <= '0;
            sp_q    <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            take_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= op_code;
                pc_q   <= pc_in;
                tgt_q  <= tgt_w;
                sp_q   <= r12_in;
                take_q <= take_w;
            end
            if (state_q == S_POP_LO)  hi_q <= mem_rdata;
            if (state_q == S_POP_CAP) lo_q <= mem_rdata;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        ready      = 1'b0;
        done       = 1'b0;
        pc_we      = 1'b0;
        pc_out     = '0;
        r12_we     = 1'b0;
        r12_out    = '0;
        carry_clr  = 1'b0;
        res_to_acc = 1'b0;
        exit_evt   = 1'b0;
        brk_evt    = 1'b0;
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (state_q)
            S_IDLE: ready = 1'b1;
            S_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q;
                mem_wdata = pc_q[BYTE_W-1:0];
            end
            S_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q + STEP1;
                mem_wdata = pc_q[ADDR_W-1:BYTE_W];
            end
            S_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp_q - STEP1;
            end
            S_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = sp_q - STEP2;
            end
            S_POP_CAP: ;
            S_FINISH: begin
                done = 1'b1;
                if (op_q == OPC_SUBCALL) begin
                    pc_we      = 1'b1;
                    pc_out     = tgt_q;
                    r12_we     = 1'b1;
                    r12_out    = sp_q + STEP2;
                    carry_clr  = 1'b1;
                    res_to_acc = 1'b1;
                end else if (op_q == OPC_SUBRET) begin
                    pc_we   = 1'b1;
                    pc_out  = {hi_q, lo_q};
                    r12_we  = 1'b1;
                    r12_out = sp_q - STEP2;
                end else begin
                    exit_evt = (op_q == OPC_EXIT);
                    brk_evt  = (op_q == OPC_BREAK);
                    pc_we    = take_q;
                    pc_out   = take_q ? tgt_q : pc_q;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br16_unit_chk.sv
module br16_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              done,
    input logic              pc_we,
    input logic              r12_we,
    input logic              carry_clr,
    input logic              res_to_acc,
    input logic              exit_evt,
    input logic              brk_evt,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_PUSH_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R4

    AST_POP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ADDR_W'($past(mem_addr) - 1'b1))); // R5

    AST_CALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        carry_clr |-> (res_to_acc && pc_we && r12_we && done)); // R4

    AST_BRANCH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r12_we) |-> (!carry_clr && !res_to_acc)); // R3

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exit_evt, brk_evt, pc_we})); // R6

    AST_EVENT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_evt || brk_evt) |-> (done && !mem_we && !mem_re)); // R6

    AST_MEM_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_we && !mem_re && !done)); // R10
endmodule

bind br16_unit br16_unit_chk #(.ADDR_W(2*BYTE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready      (ready),
    .done       (done),
    .pc_we      (pc_we),
    .r12_we     (r12_we),
    .carry_clr  (carry_clr),
    .res_to_acc (res_to_acc),
    .exit_evt   (exit_evt),
    .brk_evt    (brk_evt),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr)
);

// File: tb/br16_unit_tb.sv
module br16_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] res_val = '0;
    logic        carry_in = 1'b0;
    logic [15:0] r12_in = '0;
    logic [7:0]  mem_rdata;
    logic        ready, done, pc_we, r12_we, carry_clr, res_to_acc;
    logic        exit_evt, brk_evt, mem_we, mem_re;
    logic [15:0] pc_out, r12_out, mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    br16_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .disp(disp),
        .pc_in(pc_in), .res_val(res_val), .carry_in(carry_in), .r12_in(r12_in),
        .mem_rdata(mem_rdata), .ready(ready), .done(done), .pc_we(pc_we),
        .pc_out(pc_out), .r12_we(r12_we), .r12_out(r12_out), .carry_clr(carry_clr),
        .res_to_acc(res_to_acc), .exit_evt(exit_evt), .brk_evt(brk_evt),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // bench byte memory, registered read
    logic [7:0] tmem [0:255];
    logic [7:0] rd_q = '0;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) rd_q <= tmem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit want_take(input logic [3:0] op, input logic [15:0] r, input logic c);
        case (op)
            4'h1: return 1'b1;
            4'h2: return !c;
            4'h3: return c;
            4'h4: return r < 16'h8000;
            4'h5: return r >= 16'h8000;
            4'h6: return r == 16'h0000;
            4'h7: return r != 16'h0000;
            4'h8: return r == 16'hFFFF;
            4'h9: return r != 16'hFFFF;
            default: return 1'b0;
        endcase
    endfunction

    // captured results of one transaction
    int          lat, n_done, n_we, n_re, busy_ready;
    logic        s_pcwe, s_r12we, s_cclr, s_racc, s_exit, s_brk;
    logic [15:0] s_pc, s_r12;

    task automatic run_op(input logic [3:0] op, input logic [7:0] d, input logic [15:0] pc,
                          input logic [15:0] r, input logic c, input logic [15:0] sp, input bit hold);
        @(negedge clk);
        op_code = op; disp = d; pc_in = pc; res_val = r; carry_in = c; r12_in = sp;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat = 1; n_done = 0; n_we = 0; n_re = 0; busy_ready = 0;
        if (hold) op_code = 4'h1; else start = 1'b0;
        while (!done && lat < 12) begin
            if (ready) busy_ready++;
            if (mem_we) n_we++;
            if (mem_re) n_re++;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (done) n_done++;
        s_pcwe = pc_we; s_pc = pc_out; s_r12we = r12_we; s_r12 = r12_out;
        s_cclr = carry_clr; s_racc = res_to_acc; s_exit = exit_evt; s_brk = brk_evt;
        @(negedge clk);
        if (done) n_done++;
        chk(ready == 1'b1, "R9 ready after done", 32'(ready), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rv [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE};
        logic [7:0]  dv [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        logic [15:0] pv [4] = '{16'h0002, 16'hFFF0, 16'h8000, 16'h1235};
        logic [15:0] tgt;
        bit          tk;

        for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(ready == 1'b1, "R10 ready", 32'(ready), 32'd1);
        chk({done, pc_we, r12_we, mem_we, mem_re} == 5'b0, "R10 quiet outputs",
            32'({done, pc_we, r12_we, mem_we, mem_re}), 32'd0);
        rst_n = 1'b1;

        // sweep of every non-stack opcode
        for (int op = 0; op < 16; op++) begin
            if (op == 11 || op == 12) continue;
            for (int ri = 0; ri < 6; ri++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int di = 0; di < 4; di++) begin
                        run_op(4'(op), dv[di], pv[di], rv[ri], 1'(c), 16'h0050, 1'b0);
                        tk  = want_take(4'(op), rv[ri], 1'(c));
                        tgt = pv[di] + {{8{dv[di][7]}}, dv[di]};
                        chk(lat == 1, "R2 R8 latency", 32'(lat), 32'd1);
                        chk(n_done == 1, "R9 single done", 32'(n_done), 32'd1);
                        if (op >= 1 && op <= 9) begin
                            chk(s_pcwe == tk, "R1 taken decision", 32'(s_pcwe), 32'(tk));
                            if (tk) chk(s_pc == tgt, "R2 target", 32'(s_pc), 32'(tgt));
                            else    chk(s_pc == pv[di], "R8 fall-through pc", 32'(s_pc), 32'(pv[di]));
                            chk({s_cclr, s_racc, s_r12we} == 3'b0, "R3 flags untouched",
                                32'({s_cclr, s_racc, s_r12we}), 32'd0);
                            chk(n_we + n_re == 0, "R3 no memory", 32'(n_we + n_re), 32'd0);
                        end else if (op == 0 || op == 10) begin
                            chk(s_exit == (op == 0), "R6 exit event", 32'(s_exit), 32'(op == 0));
                            chk(s_brk == (op == 10), "R6 break event", 32'(s_brk), 32'(op == 10));
                            chk(s_pcwe == 1'b0, "R6 no pc write", 32'(s_pcwe), 32'd0);
                            chk(n_we + n_re == 0, "R6 no memory", 32'(n_we + n_re), 32'd0);
                        end else begin
                            chk({s_pcwe, s_exit, s_brk, s_r12we} == 4'b0, "R7 inert",
                                32'({s_pcwe, s_exit, s_brk, s_r12we}), 32'd0);
                            chk(s_pc == pv[di], "R7 pc past disp", 32'(s_pc), 32'(pv[di]));
                        end
                    end
                end
            end
        end

        // nested call / call / return / return
        run_op(4'hC, 8'h10, 16'h1234, 16'h0000, 1'b1, 16'h0040, 1'b0);
        chk(lat == 3, "R4 call latency", 32'(lat), 32'd3);
        chk(n_we == 2, "R4 two writes", 32'(n_we), 32'd2);
        chk({tmem[8'h41], tmem[8'h40]} == 16'h1234, "R4 bytes low first",
            32'({tmem[8'h41], tmem[8'h40]}), 32'h1234);
        chk(s_pcwe && s_pc == 16'h1244, "R4 call target", 32'(s_pc), 32'h1244);
        chk(s_r12we && s_r12 == 16'h0042, "R4 pointer +2", 32'(s_r12), 32'h0042);
        chk(s_cclr && s_racc, "R4 flags", 32'({s_cclr, s_racc}), 32'd3);

        run_op(4'hC, 8'h80, 16'hABCD, 16'h0000, 1'b0, 16'h0042, 1'b1);
        chk(n_done == 1, "R9 start ignored while busy", 32'(n_done), 32'd1);
        chk(busy_ready == 0, "R9 ready low when busy", 32'(busy_ready), 32'd0);
        chk(s_pc == 16'hAB4D, "R4 backward target", 32'(s_pc), 32'hAB4D);
        chk({tmem[8'h43], tmem[8'h42]} == 16'hABCD, "R4 second frame",
            32'({tmem[8'h43], tmem[8'h42]}), 32'hABCD);

        run_op(4'hB, 8'h00, 16'h5555, 16'h0000, 1'b1, 16'h0044, 1'b1);
        chk(lat == 4, "R5 return latency", 32'(lat), 32'd4);
        chk(n_done == 1, "R9 start ignored while popping", 32'(n_done), 32'd1);
        chk(n_re == 2 && n_we == 0, "R5 two reads", 32'(n_re), 32'd2);
        chk(s_pcwe && s_pc == 16'hABCD, "R5 popped pc", 32'(s_pc), 32'hABCD);
        chk(s_r12we && s_r12 == 16'h0042, "R5 pointer -2", 32'(s_r12), 32'h0042);
        chk({s_cclr, s_racc} == 2'b0, "R5 no flags", 32'({s_cclr, s_racc}), 32'd0);

        run_op(4'hB, 8'h00, 16'h5555, 16'h0000, 1'b0, 16'h0042, 1'b0);
        chk(s_pc == 16'h1234, "R5 outer return", 32'(s_pc), 32'h1234);
        chk(s_r12 == 16'h0040, "R5 outer pointer", 32'(s_r12), 32'h0040);

        // call with target wrapping through zero
        run_op(4'hC, 8'h7F, 16'hFFF0, 16'h0000, 1'b0, 16'h00FE, 1'b0);
        chk(s_pc == 16'h006F, "R2 R4 wrap target", 32'(s_pc), 32'h006F);
        chk(s_r12 == 16'h0100, "R4 pointer wrap", 32'(s_r12), 32'h0100);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule